// File: doc/BRIEF.md
# Virtually Tagged Partial-Translation Cache

This block is a small, fully associative store of upper-level page-table pointers. It serves a walker that resolves virtual addresses through a four-level radix tree. Each level of the tree is selected by a 9-bit slice of the virtual address. An entry is keyed by one, two or three of the top index slices, and it holds the physical base of the table one level further down. Leaf translations are never held here.

A lookup is purely combinational. It compares the virtual address against every entry in the same cycle and reports the deepest entry that matched, together with the table base that entry points to. The walker then starts at the level just below that entry and skips all the reads above it. When nothing matches, the block reports depth zero and passes the root table base through, so the walk begins at the top.

The walker installs pointers through a fill port as it reads them from memory. A fill that repeats an existing key refreshes that entry in place. Any other fill takes an empty slot, or evicts the least recently used entry when every slot is full. A flush input empties the whole array. All three kinds of entry share a single array.

Top module: `xlat_prefix_cache`

## Requirements
- R1: The index slices are taken from fixed address bits: the top level uses bits [47:39], the second level bits [38:30] and the third level bits [29:21]. Bits [20:0] never affect a match.
- R2: An entry of depth 1 matches on the top slice alone, depth 2 on the top two slices, and depth 3 on all three slices. Slices below an entry's depth are ignored.
- R3: When several entries match, `matchDepth` reports the largest matching depth, and `tableBase` returns that entry's stored base. The depth codes are 0 for none, and 1, 2 or 3 for the number of slices matched.
- R4: When no valid entry matches, `matchDepth` is 0 and `tableBase` equals `rootBase`.
- R5: The lookup outputs follow `lookupVa` within the same cycle. A fill changes them only after the next rising clock edge.
- R6: A fill with `fillDepth` = 0 is ignored. It installs nothing and changes no slot occupancy.
- R7: A fill whose depth and covered slices equal those of a valid entry overwrites that entry's base in place, so no second copy is created.
- R8: A new fill goes into the lowest-numbered empty slot whenever any slot is empty.
- R9: When every slot is full, a new fill evicts the least recently used entry. Recency is refreshed by every fill and by every hitting lookup with `lookupValid` high. After a flush, slot 0 is the most recently used and slot 15 the least.
- R10: A flush invalidates every entry at the next rising edge. A fill presented in the same cycle is discarded.
- R11: After reset the array is empty, so every lookup misses.
- R12: When a fill and a hitting lookup with `lookupValid` occur in the same cycle, only the fill refreshes recency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| rootBase | input | 40 | Physical base of the top-level table, returned on a miss |
| lookupValid | input | 1 | Marks a real lookup; a hit then refreshes recency |
| lookupVa | input | 48 | Virtual address being looked up |
| matchDepth | output | 2 | Number of index slices covered by the deepest match (0 = miss) |
| tableBase | output | 40 | Physical base of the table at which the walk resumes |
| fillValid | input | 1 | Install request |
| fillVa | input | 48 | Virtual address whose upper slices form the new key |
| fillDepth | input | 2 | Depth of the entry to install (1 to 3; 0 means no install) |
| fillBase | input | 40 | Table base stored with the new entry |
| flush | input | 1 | Invalidate all entries at the next edge |

## Verification
The bench targets nested keys, where a depth-1, a depth-2 and a depth-3 entry all cover the same address. A selector that took the first or the shallowest match would return a shallower depth and force the walker to read levels it could skip. It also exercises a refill of an existing key. A design without the in-place overwrite would use up a second slot and later evict the wrong entry. The full-array case is driven with one entry freshly touched by a lookup, and with a lookup and a fill in the same cycle. A design with wrong recency would evict the touched entry or keep the stale one. A long mixed sweep over a small pool of index values then checks every lookup against an arithmetic model of occupancy and recency. That sweep catches depth-0 fills that leak in and flushes that lose to fills.

// File: rtl/tc_pkg.sv
package tc_pkg;
  // Widest slot number the strobe struct can carry (up to 256 entries).
  localparam int TC_SLOT_W = 8;

  // Number of upper index slices an entry covers.
  localparam logic [1:0] TC_DEPTH_NONE = 2'd0;
  localparam logic [1:0] TC_DEPTH_TOP  = 2'd1;
  localparam logic [1:0] TC_DEPTH_MID  = 2'd2;
  localparam logic [1:0] TC_DEPTH_LOW  = 2'd3;

  // Strobes from replacement control to the entry array.
  typedef struct packed {
    logic                 clearAll;
    logic                 writeEn;
    logic [TC_SLOT_W-1:0] writeSlot;
  } tc_strobe_t;
endpackage

// File: rtl/tc_entry_array.sv
module tc_entry_array
  import tc_pkg::*;
#(
  parameter  int ENTRIES = 16,
  parameter  int IDX_W   = 9,
  parameter  int BASE_W  = 40,
  localparam int TAG_W   = 3 * IDX_W,
  localparam int SLOT_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tc_strobe_t         strobes,
  input  logic [TAG_W-1:0]   fillTag,
  input  logic [1:0]         fillDepth,
  input  logic [BASE_W-1:0]  fillBase,
  input  logic [TAG_W-1:0]   lookTag,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] dupVec,
  output logic               hitFound,
  output logic [SLOT_W-1:0]  hitSlot,
  output logic [1:0]         hitDepth,
  output logic [BASE_W-1:0]  hitBase
);

  // Keep only the slices an entry of this depth covers; clear the rest.
  function automatic logic [TAG_W-1:0] maskTag(input logic [TAG_W-1:0] tag,
                                               input logic [1:0] depth);
    logic [TAG_W-1:0] kept;
    kept = '0;
    for (int k = 0; k < 3; k++) begin
      if (int'(depth) > k)
        kept[TAG_W-1-k*IDX_W -: IDX_W] = tag[TAG_W-1-k*IDX_W -: IDX_W];
    end
    return kept;
  endfunction

  logic [ENTRIES-1:0] validQ;
  logic [1:0]         depthQ [ENTRIES];
  logic [TAG_W-1:0]   tagQ   [ENTRIES];
  logic [BASE_W-1:0]  baseQ  [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] deeperVec;
  logic [TAG_W-1:0]   fillKey;

  assign fillKey  = maskTag(fillTag, fillDepth);
  assign validVec = validQ;

  // Stored tags are already masked, so each compare is a plain equality.
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign matchVec[g] = validQ[g] && (depthQ[g] != TC_DEPTH_NONE) &&
                         (maskTag(lookTag, depthQ[g]) == tagQ[g]);
    assign dupVec[g]   = validQ[g] && (depthQ[g] == fillDepth) &&
                         (tagQ[g] == fillKey);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        validQ[i] <= 1'b0;
        depthQ[i] <= TC_DEPTH_NONE;
        tagQ[i]   <= '0;
        baseQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobes.clearAll) begin
          validQ[i] <= 1'b0;
        end else if (strobes.writeEn && strobes.writeSlot == TC_SLOT_W'(i)) begin
          validQ[i] <= 1'b1;
          depthQ[i] <= fillDepth;
          tagQ[i]   <= fillKey;
          baseQ[i]  <= fillBase;
        end
      end
    end
  end

  // Deepest match wins; on a tie the lower slot is kept.
  always_comb begin
    hitFound = 1'b0;
    hitSlot  = '0;
    hitDepth = TC_DEPTH_NONE;
    hitBase  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i] && depthQ[i] > hitDepth) begin
        hitFound = 1'b1;
        hitSlot  = SLOT_W'(i);
        hitDepth = depthQ[i];
        hitBase  = baseQ[i];
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gDeeper
    assign deeperVec[g] = matchVec[g] && (depthQ[g] > hitDepth);
  end

  AST_DEEPEST_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    deeperVec == '0); // R3

  AST_NO_TWIN_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $countones(dupVec) <= 1); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> validQ == '0); // R10

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeEn && !strobes.clearAll) |=>
      validQ[$past(strobes.writeSlot[SLOT_W-1:0])]); // R5

endmodule

// File: rtl/tc_repl_ctrl.sv
module tc_repl_ctrl
  import tc_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int SLOT_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flushIn,
  input  logic               fillReq,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] dupVec,
  input  logic               lookTouch,
  input  logic [SLOT_W-1:0]  hitSlot,
  output tc_strobe_t         strobes
);

  localparam logic [SLOT_W-1:0] OLDEST = SLOT_W'(ENTRIES - 1);

  // Recency rank per slot: 0 is most recent, ENTRIES-1 is the victim.
  logic [SLOT_W-1:0]  rankQ [ENTRIES];
  logic [SLOT_W-1:0]  dupSlot, freeSlot, oldSlot, target, touchSlot;
  logic               writeEn, touchEn;
  logic [ENTRIES-1:0] oldestVec, newestVec;

  always_comb begin
    dupSlot  = '0;
    freeSlot = '0;
    oldSlot  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (dupVec[i])   dupSlot  = SLOT_W'(i);
      if (!validVec[i]) freeSlot = SLOT_W'(i);
      if (rankQ[i] == OLDEST) oldSlot = SLOT_W'(i);
    end
    if (|dupVec)         target = dupSlot;
    else if (!(&validVec)) target = freeSlot;
    else                 target = oldSlot;
  end

  assign writeEn   = fillReq && !flushIn;
  assign touchEn   = writeEn || (lookTouch && !fillReq && !flushIn);
  assign touchSlot = writeEn ? target : hitSlot;

  assign strobes.clearAll  = flushIn;
  assign strobes.writeEn   = writeEn;
  assign strobes.writeSlot = TC_SLOT_W'(target);

  always_ff @(posedge clk) begin
    if (!rstN || flushIn) begin
      for (int i = 0; i < ENTRIES; i++) rankQ[i] <= SLOT_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (SLOT_W'(i) == touchSlot)        rankQ[i] <= '0;
        else if (rankQ[i] < rankQ[touchSlot]) rankQ[i] <= rankQ[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gRank
    assign oldestVec[g] = (rankQ[g] == OLDEST);
    assign newestVec[g] = (rankQ[g] == '0);
  end

  AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rstN)
    $countones(oldestVec) == 1); // R9

  AST_ONE_NEWEST: assert property (@(posedge clk) disable iff (!rstN)
    $countones(newestVec) == 1); // R9

endmodule

// File: rtl/xlat_prefix_cache.sv
module xlat_prefix_cache
  import tc_pkg::*;
#(
  parameter  int ENTRIES = 16,
  parameter  int IDX_W   = 9,
  parameter  int PAGE_W  = 12,
  parameter  int BASE_W  = 40,
  localparam int VA_W    = PAGE_W + 4 * IDX_W,
  localparam int TAG_W   = 3 * IDX_W,
  localparam int SLOT_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BASE_W-1:0] rootBase,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVa,
  output logic [1:0]        matchDepth,
  output logic [BASE_W-1:0] tableBase,
  input  logic              fillValid,
  input  logic [VA_W-1:0]   fillVa,
  input  logic [1:0]        fillDepth,
  input  logic [BASE_W-1:0] fillBase,
  input  logic              flush
);

  tc_strobe_t         strobes;
  logic [TAG_W-1:0]   lookTag, fillTag;
  logic [ENTRIES-1:0] validVec, dupVec;
  logic               hitFound, fillReq, lookTouch;
  logic [SLOT_W-1:0]  hitSlot;
  logic [1:0]         hitDepth;
  logic [BASE_W-1:0]  hitBase;
  logic               unusedLowBits;

  assign lookTag = lookupVa[VA_W-1 -: TAG_W];
  assign fillTag = fillVa[VA_W-1 -: TAG_W];
  assign unusedLowBits = ^{lookupVa[VA_W-TAG_W-1:0], fillVa[VA_W-TAG_W-1:0]};

  assign fillReq   = fillValid && (fillDepth != TC_DEPTH_NONE);
  assign lookTouch = lookupValid && hitFound;

  tc_repl_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .flushIn   (flush),
    .fillReq   (fillReq),
    .validVec  (validVec),
    .dupVec    (dupVec),
    .lookTouch (lookTouch),
    .hitSlot   (hitSlot),
    .strobes   (strobes)
  );

  tc_entry_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_array (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .fillTag   (fillTag),
    .fillDepth (fillDepth),
    .fillBase  (fillBase),
    .lookTag   (lookTag),
    .validVec  (validVec),
    .dupVec    (dupVec),
    .hitFound  (hitFound),
    .hitSlot   (hitSlot),
    .hitDepth  (hitDepth),
    .hitBase   (hitBase)
  );

  assign matchDepth = hitFound ? hitDepth : TC_DEPTH_NONE;
  assign tableBase  = hitFound ? hitBase  : rootBase;

  AST_NULL_FILL_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillDepth == TC_DEPTH_NONE && !flush) |=>
      validVec == $past(validVec)); // R6

endmodule

// File: tb/xlat_prefix_cache_tb.sv
`timescale 1ns/1ps
module xlat_prefix_cache_tb;

  localparam int N = 16;
  localparam logic [39:0] ROOT = 40'hABCDE_12345;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [39:0] rootBase = ROOT;
  logic        lookupValid = 1'b0;
  logic [47:0] lookupVa = '0;
  logic [1:0]  matchDepth;
  logic [39:0] tableBase;
  logic        fillValid = 1'b0;
  logic [47:0] fillVa = '0;
  logic [1:0]  fillDepth = '0;
  logic [39:0] fillBase = '0;
  logic        flush = 1'b0;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xlat_prefix_cache u_dut (
    .clk(clk), .rstN(rstN), .rootBase(rootBase),
    .lookupValid(lookupValid), .lookupVa(lookupVa),
    .matchDepth(matchDepth), .tableBase(tableBase),
    .fillValid(fillValid), .fillVa(fillVa), .fillDepth(fillDepth),
    .fillBase(fillBase), .flush(flush)
  );

  // Arithmetic model of the array.
  bit          mVal  [N];
  int          mDep  [N];
  logic [26:0] mTag  [N];
  logic [39:0] mBase [N];
  int          mRank [N];

  function automatic logic [26:0] keyOf(input logic [47:0] va, input int d);
    logic [26:0] t;
    t = va[47:21];
    case (d)
      1: return {t[26:18], 18'd0};
      2: return {t[26:9], 9'd0};
      3: return t;
      default: return '0;
    endcase
  endfunction

  function automatic logic [47:0] mkVa(input int a, input int b, input int c, input int low);
    return {9'(a), 9'(b), 9'(c), 21'(low)};
  endfunction

  task automatic modelLook(input logic [47:0] va, output int d, output logic [39:0] b,
                           output int idx);
    d = 0; b = ROOT; idx = -1;
    for (int i = 0; i < N; i++)
      if (mVal[i] && mDep[i] > d && keyOf(va, mDep[i]) == mTag[i]) begin
        d = mDep[i]; b = mBase[i]; idx = i;
      end
  endtask

  task automatic touch(input int t);
    int r;
    r = mRank[t];
    for (int j = 0; j < N; j++) if (mRank[j] < r) mRank[j]++;
    mRank[t] = 0;
  endtask

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin mVal[i] = 0; mRank[i] = i; end
  endtask

  task automatic modelEdge(input bit fv, input logic [47:0] fva, input int fd,
                           input logic [39:0] fb, input bit lv, input logic [47:0] lva,
                           input bit fl);
    int slot, d, idx;
    logic [39:0] b;
    logic [26:0] k;
    if (fl) modelReset();
    else if (fv && fd != 0) begin
      k = keyOf(fva, fd); slot = -1;
      for (int i = 0; i < N; i++)
        if (slot < 0 && mVal[i] && mDep[i] == fd && mTag[i] == k) slot = i;
      for (int i = 0; i < N; i++) if (slot < 0 && !mVal[i]) slot = i;
      for (int i = 0; i < N; i++) if (slot < 0 && mRank[i] == N - 1) slot = i;
      mVal[slot] = 1; mDep[slot] = fd; mTag[slot] = k; mBase[slot] = fb;
      touch(slot);
    end else if (lv) begin
      modelLook(lva, d, b, idx);
      if (idx >= 0) touch(idx);
    end
  endtask

  task automatic check(input string req, input int expD, input logic [39:0] expB);
    testsRun++;
    if (int'(matchDepth) != expD || tableBase !== expB) begin
      testsFailed++;
      $display("FAIL %s: depth=%0d base=%h, expected depth=%0d base=%h",
               req, matchDepth, tableBase, expD, expB);
    end
  endtask

  // One cycle: drive at the falling edge, compare the combinational lookup,
  // then advance the model across the rising edge.
  task automatic cycle(input string req, input bit fv, input logic [47:0] fva, input int fd,
                       input logic [39:0] fb, input bit lv, input logic [47:0] lva,
                       input bit fl);
    int d, idx;
    logic [39:0] b;
    @(negedge clk);
    fillValid = fv; fillVa = fva; fillDepth = 2'(fd); fillBase = fb;
    lookupValid = lv; lookupVa = lva; flush = fl;
    #1;
    modelLook(lva, d, b, idx);
    check(req, d, b);
    @(posedge clk);
    modelEdge(fv, fva, fd, fb, lv, lva, fl);
  endtask

  task automatic look(input string req, input logic [47:0] va, input bit lv);
    cycle(req, 0, '0, 0, '0, lv, va, 0);
  endtask

  task automatic fill(input string req, input logic [47:0] va, input int d,
                      input logic [39:0] b);
    cycle(req, 1, va, d, b, 0, va, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    testsFailed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    int seed;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R11: empty after reset.
    look("R11", mkVa(0, 0, 0, 0), 1);
    look("R11", mkVa(511, 511, 511, 'h1FFFFF), 1);
    // R4: miss returns root base.
    look("R4", mkVa(5, 7, 9, 0), 0);

    // R5: a fill is not visible in its own cycle.
    fill("R5", mkVa(5, 0, 0, 0), 1, 40'h11111);
    look("R5", mkVa(5, 0, 0, 0), 0);
    // R2: depth-1 entry ignores lower slices.
    look("R2", mkVa(5, 7, 9, 3), 0);
    look("R4", mkVa(6, 7, 9, 3), 0);

    fill("R2", mkVa(5, 7, 0, 0), 2, 40'h22222);
    look("R3", mkVa(5, 7, 33, 0), 0);
    look("R2", mkVa(5, 8, 9, 0), 0);

    fill("R3", mkVa(5, 7, 9, 0), 3, 40'h33333);
    look("R3", mkVa(5, 7, 9, 0), 0);
    // R1: page offset and the bits below the third slice never matter.
    look("R1", mkVa(5, 7, 9, 'h1FFFFF), 0);
    look("R1", mkVa(5, 7, 10, 0), 0);

    // R6: depth-0 fill installs nothing.
    fill("R6", mkVa(6, 0, 0, 0), 0, 40'h66666);
    look("R6", mkVa(6, 0, 0, 0), 0);

    // R7: refill of an existing key replaces its base.
    fill("R7", mkVa(5, 0, 0, 0), 1, 40'h77777);
    look("R7", mkVa(5, 8, 8, 0), 0);

    // R10: flush beats a simultaneous fill.
    cycle("R10", 1, mkVa(9, 0, 0, 0), 1, 40'h99999, 0, mkVa(9, 0, 0, 0), 1);
    look("R10", mkVa(9, 0, 0, 0), 0);
    look("R10", mkVa(5, 7, 9, 0), 0);

    // R8: sixteen distinct fills occupy slots in order.
    for (int k = 0; k < N; k++) fill("R8", mkVa(k, 0, 0, 0), 1, 40'(100 + k));
    for (int k = 0; k < N; k++) look("R8", mkVa(k, 1, 1, 0), 0);

    // R9: touching the oldest entry shifts the victim to the next one.
    look("R9", mkVa(0, 0, 0, 0), 1);
    fill("R9", mkVa(200, 0, 0, 0), 1, 40'd200);
    look("R9", mkVa(1, 0, 0, 0), 0);
    look("R9", mkVa(0, 0, 0, 0), 0);
    look("R9", mkVa(200, 0, 0, 0), 0);

    // R12: a lookup touch in a fill cycle is dropped, so entry 2 is evicted.
    cycle("R12", 1, mkVa(201, 0, 0, 0), 1, 40'd201, 1, mkVa(2, 0, 0, 0), 0);
    look("R12", mkVa(2, 0, 0, 0), 0);
    look("R12", mkVa(201, 0, 0, 0), 0);

    // Mixed sweep over a small index pool against the model.
    seed = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      int pool [4];
      logic [47:0] fva, lva;
      bit fv, lv, fl;
      int fd;
      pool = '{0, 1, 2, 511};
      seed = seed * 1103515245 + 12345;
      fva = mkVa(pool[(seed >> 4) & 3], pool[(seed >> 6) & 3], pool[(seed >> 8) & 3], seed >> 10);
      fd  = (seed >> 20) & 3;
      fv  = ((seed >> 22) & 1) == 1;
      seed = seed * 1103515245 + 12345;
      lva = mkVa(pool[(seed >> 4) & 3], pool[(seed >> 6) & 3], pool[(seed >> 8) & 3], seed >> 10);
      lv  = ((seed >> 22) & 1) == 1;
      fl  = ((seed >> 24) & 63) == 0;
      cycle("R9", fv, fva, fd, 40'(seed), lv, lva, fl);
    end

    summary();
  end

endmodule